// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block sits on the processor's request path. For each bus address it decides how the access is routed. It reports whether the access may read, whether it may write, whether it may be cached, whether it goes to the PCI side, and whether the graphics path takes it. First, an optional wrap mask clears address bit 20. SMI-mode accesses are exempt from this mask.

The masked address is then sorted into one of three groups:
- the area between 640 KB and 1 MB, which holds nineteen programmable regions;
- ordinary system memory below a programmable top-of-memory limit;
- space at or above that limit, which is sent to PCI.

The three display regions at the start of the window each have an extra redirect bit. That bit hands the access to the graphics path. The downstream controllers are not part of this block; it produces only the routing decision.

Software programs the block through a small write port. The selector field of the port is decoded as follows:

| Selector | What the write sets |
|---|---|
| 0 to 18 | One region's four attribute bits, taken from data bits 3:0 |
| 19 | The three redirect bits, taken from data bits 2:0 |
| 20 | The wrap-mask enable, taken from data bit 0 |
| 21 | The full 32-bit top-of-memory address |

Responses appear one clock after the request is presented.

Top module: `legacy_region_decoder`

## Requirements
- R1: When the wrap-mask enable (selector 20, data bit 0) is 1 and `req_smi_i` is 0, the effective address has bit 20 forced to 0. This effective address is reported on `rsp_addr_o` and is the address that gets classified.
- R2: When `req_smi_i` is 1, the address is not masked. `rsp_addr_o` equals `req_addr_i` and is classified unchanged.
- R3: An effective address below A0000h that is also below top-of-memory reports read, write and cacheable set, with PCI and redirect clear.
- R4: Outside the 640 KB–1 MB window, an address from 100000h up to top-of-memory minus 1 reports read, write and cacheable. Any address at or above top-of-memory reports only the PCI flag.
- R5: There are three display regions. Region 0 covers A0000h–AFFFFh, region 1 covers B0000h–B7FFFh, and region 2 covers B8000h–BFFFFh. Each reports the attribute bits written through selector 0, 1 or 2, and the boundaries are inclusive as listed.
- R6: Region 3+k covers C0000h+k·4000h through C0000h+k·4000h+3FFFh, for k = 0..15. It reports the bits written through selector 3+k.
- R7: Within an attribute nibble, bit 0 is read, bit 1 is write, bit 2 is cacheable and bit 3 is PCI. All 16 combinations come out on the corresponding outputs unchanged.
- R8: Redirect bit d (selector 19, data bit d) applies to display region d only. When it is set, `rsp_vga_o` is 1 and `rsp_pci_o` is 0, while read, write and cacheable keep their programmed values. ROM segments never report redirect.
- R9: After reset, every control bit and top-of-memory read as zero. Window accesses therefore report no flags, and accesses outside the window report PCI only.
- R10: A request presented with `req_valid_i` in one cycle is answered on the outputs in the next cycle, with `rsp_valid_o` set. When no request is presented, `rsp_valid_o` goes to 0 and the other outputs hold their last values.
- R11: `rsp_permit_o` is 1 exactly when the request's read strobe meets a reported read enable, or its write strobe meets a reported write enable.
- R12: A configuration write affects requests from the following cycle on; a request in the same cycle still sees the old setting. Writes to selectors 22 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_addr_i | input | 32 | Bus address of the request |
| req_rd_i | input | 1 | Request is a read |
| req_wr_i | input | 1 | Request is a write |
| req_smi_i | input | 1 | Request is made in SMI mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 5 | Configuration selector |
| cfg_wdata_i | input | 32 | Configuration write data |
| rsp_valid_o | output | 1 | Response holds a fresh decision |
| rsp_addr_o | output | 32 | Effective (possibly masked) address |
| rsp_rd_en_o | output | 1 | Read allowed |
| rsp_wr_en_o | output | 1 | Write allowed |
| rsp_cache_o | output | 1 | Cacheable |
| rsp_pci_o | output | 1 | Forward to PCI |
| rsp_vga_o | output | 1 | Redirect to the graphics path |
| rsp_permit_o | output | 1 | The request's own strobe is allowed |

## Verification
The assertions assume that every input is at a known level once reset is released. They also assume that `req_smi_i`, `req_rd_i` and `req_wr_i` only matter in cycles where `req_valid_i` is high. The stimulus keeps to these assumptions: it changes every input only on the falling clock edge, and it parks the request inputs at zero between scenarios. The stimulus programs top-of-memory only with values above 1 MB, which keeps the in-window and above-limit cases apart. Every window address the stimulus uses lies exactly on a region boundary or on the last byte of a region.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

    localparam int NUM_DISP = 3;

    typedef struct packed {
        logic rd;
        logic wr;
        logic cache;
        logic pci;
    } attr_t;

    // nibble layout: bit0 read, bit1 write, bit2 cacheable, bit3 PCI
    function automatic attr_t nib_to_attr(input logic [3:0] nib);
        attr_t a;
        a.rd    = nib[0];
        a.wr    = nib[1];
        a.cache = nib[2];
        a.pci   = nib[3];
        return a;
    endfunction

endpackage

// File: rtl/lrd_cfg_regs.sv
module lrd_cfg_regs
    import lrd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_REG = 19,
    parameter int SEL_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we_i,
    input  logic [SEL_W-1:0]       cfg_sel_i,
    input  logic [ADDR_W-1:0]      cfg_wdata_i,
    output attr_t [NUM_REG-1:0]    region_attr_o,
    output logic  [NUM_DISP-1:0]   vga_en_o,
    output logic                   a20_mask_o,
    output logic  [ADDR_W-1:0]     tom_o
);

    localparam int SEL_VGA = NUM_REG;
    localparam int SEL_A20 = NUM_REG + 1;
    localparam int SEL_TOM = NUM_REG + 2;

    typedef struct packed {
        attr_t [NUM_REG-1:0]  attr;
        logic  [NUM_DISP-1:0] vga;
        logic                 a20;
        logic  [ADDR_W-1:0]   tom;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) begin
            for (int i = 0; i < NUM_REG; i++) begin
                if (cfg_sel_i == SEL_W'(i)) begin
                    cfg_d.attr[i] = nib_to_attr(cfg_wdata_i[3:0]);
                end
            end
            if (cfg_sel_i == SEL_W'(SEL_VGA)) begin
                cfg_d.vga = cfg_wdata_i[NUM_DISP-1:0];
            end
            if (cfg_sel_i == SEL_W'(SEL_A20)) begin
                cfg_d.a20 = cfg_wdata_i[0];
            end
            if (cfg_sel_i == SEL_W'(SEL_TOM)) begin
                cfg_d.tom = cfg_wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign region_attr_o = cfg_q.attr;
    assign vga_en_o      = cfg_q.vga;
    assign a20_mask_o    = cfg_q.a20;
    assign tom_o         = cfg_q.tom;

    AST_UNUSED_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && (cfg_sel_i > SEL_W'(SEL_TOM))) |=> $stable(cfg_q)); // R12

endmodule

// File: rtl/lrd_addr_map.sv
module lrd_addr_map
    import lrd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_ROM_SEG = 16,
    parameter int SEG_SHIFT   = 14
) (
    input  logic [ADDR_W-1:0]               addr_i,
    output logic [NUM_ROM_SEG+NUM_DISP-1:0] hit_o
);

    localparam int NUM_REG = NUM_ROM_SEG + NUM_DISP;
    localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'(32'h000C_0000);
    localparam logic [ADDR_W-1:0] SEG_SIZE = ADDR_W'(1) << SEG_SHIFT;

    function automatic logic [ADDR_W-1:0] region_lo(input int idx);
        case (idx)
            0:       return ADDR_W'(32'h000A_0000);
            1:       return ADDR_W'(32'h000B_0000);
            2:       return ADDR_W'(32'h000B_8000);
            default: return ROM_BASE + ADDR_W'(idx - NUM_DISP) * SEG_SIZE;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] region_hi(input int idx);
        case (idx)
            0:       return ADDR_W'(32'h000B_0000);
            1:       return ADDR_W'(32'h000B_8000);
            2:       return ROM_BASE;
            default: return region_lo(idx) + SEG_SIZE;
        endcase
    endfunction

    for (genvar g = 0; g < NUM_REG; g++) begin : g_region
        localparam logic [ADDR_W-1:0] LO = region_lo(g);
        localparam logic [ADDR_W-1:0] HI = region_hi(g);
        assign hit_o[g] = (addr_i >= LO) && (addr_i < HI);
    end

endmodule

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder
    import lrd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_ROM_SEG = 16,
    parameter int SEG_SHIFT   = 14,
    parameter int WRAP_BIT    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic                req_rd_i,
    input  logic                req_wr_i,
    input  logic                req_smi_i,
    input  logic                cfg_we_i,
    input  logic [$clog2(NUM_ROM_SEG+NUM_DISP+3)-1:0] cfg_sel_i,
    input  logic [ADDR_W-1:0]   cfg_wdata_i,
    output logic                rsp_valid_o,
    output logic [ADDR_W-1:0]   rsp_addr_o,
    output logic                rsp_rd_en_o,
    output logic                rsp_wr_en_o,
    output logic                rsp_cache_o,
    output logic                rsp_pci_o,
    output logic                rsp_vga_o,
    output logic                rsp_permit_o
);

    localparam int NUM_REG = NUM_ROM_SEG + NUM_DISP;
    localparam int SEL_W   = $clog2(NUM_REG + 3);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        attr_t             attr;
        logic              vga;
        logic              permit;
    } rsp_t;

    attr_t [NUM_REG-1:0]  region_attr;
    logic  [NUM_DISP-1:0] vga_en;
    logic                 a20_mask;
    logic  [ADDR_W-1:0]   tom;
    logic  [ADDR_W-1:0]   eff_addr;
    logic  [NUM_REG-1:0]  hit;
    logic                 above_tom;
    rsp_t                 rsp_d, rsp_q;

    lrd_cfg_regs #(
        .ADDR_W  (ADDR_W),
        .NUM_REG (NUM_REG),
        .SEL_W   (SEL_W)
    ) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we_i      (cfg_we_i),
        .cfg_sel_i     (cfg_sel_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .region_attr_o (region_attr),
        .vga_en_o      (vga_en),
        .a20_mask_o    (a20_mask),
        .tom_o         (tom)
    );

    always_comb begin
        eff_addr = req_addr_i;
        if (a20_mask && !req_smi_i) begin
            eff_addr[WRAP_BIT] = 1'b0;
        end
    end

    lrd_addr_map #(
        .ADDR_W      (ADDR_W),
        .NUM_ROM_SEG (NUM_ROM_SEG),
        .SEG_SHIFT   (SEG_SHIFT)
    ) u_map (
        .addr_i (eff_addr),
        .hit_o  (hit)
    );

    assign above_tom = (eff_addr >= tom);

    always_comb begin
        logic [3:0] acc;
        logic       vga;
        attr_t      a;
        acc = '0;
        vga = 1'b0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (hit[i]) begin
                acc = acc | region_attr[i];
            end
        end
        for (int d = 0; d < NUM_DISP; d++) begin
            if (hit[d] && vga_en[d]) begin
                vga = 1'b1;
            end
        end
        if (|hit) begin
            a = attr_t'(acc);
            if (vga) begin
                a.pci = 1'b0;
            end
        end else if (above_tom) begin
            a = '{rd: 1'b0, wr: 1'b0, cache: 1'b0, pci: 1'b1};
        end else begin
            a = '{rd: 1'b1, wr: 1'b1, cache: 1'b1, pci: 1'b0};
        end

        rsp_d       = rsp_q;
        rsp_d.valid = req_valid_i;
        if (req_valid_i) begin
            rsp_d.addr   = eff_addr;
            rsp_d.attr   = a;
            rsp_d.vga    = vga;
            rsp_d.permit = (req_rd_i && a.rd) || (req_wr_i && a.wr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o  = rsp_q.valid;
    assign rsp_addr_o   = rsp_q.addr;
    assign rsp_rd_en_o  = rsp_q.attr.rd;
    assign rsp_wr_en_o  = rsp_q.attr.wr;
    assign rsp_cache_o  = rsp_q.attr.cache;
    assign rsp_pci_o    = rsp_q.attr.pci;
    assign rsp_vga_o    = rsp_q.vga;
    assign rsp_permit_o = rsp_q.permit;

    AST_WRAP_BIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && a20_mask && !req_smi_i) |=> !rsp_addr_o[WRAP_BIT]); // R1

    AST_SMI_ADDR_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_smi_i) |=> (rsp_addr_o == $past(req_addr_i))); // R2

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R5

    AST_ABOVE_LIMIT_PCI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !(|hit) && above_tom) |=>
            (rsp_pci_o && !rsp_rd_en_o && !rsp_wr_en_o && !rsp_cache_o)); // R4

    AST_REDIRECT_BEATS_PCI: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !(rsp_vga_o && rsp_pci_o)); // R8

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o); // R10

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && $stable({rsp_addr_o, rsp_rd_en_o, rsp_wr_en_o,
                                                   rsp_cache_o, rsp_pci_o, rsp_vga_o,
                                                   rsp_permit_o}))); // R10

    AST_PERMIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_permit_o |-> (rsp_rd_en_o || rsp_wr_en_o)); // R11

endmodule

// File: tb/legacy_region_decoder_test.sv
module legacy_region_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic        req_smi = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_rd, rsp_wr, rsp_cache, rsp_pci, rsp_vga, rsp_permit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    legacy_region_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_addr_i   (req_addr),
        .req_rd_i     (req_rd),
        .req_wr_i     (req_wr),
        .req_smi_i    (req_smi),
        .cfg_we_i     (cfg_we),
        .cfg_sel_i    (cfg_sel),
        .cfg_wdata_i  (cfg_wdata),
        .rsp_valid_o  (rsp_valid),
        .rsp_addr_o   (rsp_addr),
        .rsp_rd_en_o  (rsp_rd),
        .rsp_wr_en_o  (rsp_wr),
        .rsp_cache_o  (rsp_cache),
        .rsp_pci_o    (rsp_pci),
        .rsp_vga_o    (rsp_vga),
        .rsp_permit_o (rsp_permit)
    );

    // flags order: {rd, wr, cache, pci, vga}
    task automatic expect_rsp(input string tag, input logic ev, input logic [31:0] ea,
                              input logic [4:0] ef, input logic ep);
        logic [4:0] af;
        af = {rsp_rd, rsp_wr, rsp_cache, rsp_pci, rsp_vga};
        n_chk++;
        if (rsp_valid !== ev || rsp_addr !== ea || af !== ef || rsp_permit !== ep) begin
            n_bad++;
            $display("FAIL %s: got v=%b addr=%h flags=%b permit=%b, expected v=%b addr=%h flags=%b permit=%b",
                     tag, rsp_valid, rsp_addr, af, rsp_permit, ev, ea, ef, ep);
        end
    endtask

    // starts and ends on a falling edge
    task automatic probe(input logic [31:0] a, input logic rd, input logic wr, input logic smi);
        req_valid = 1'b1; req_addr = a; req_rd = rd; req_wr = wr; req_smi = smi;
        @(negedge clk);
        req_valid = 1'b0; req_rd = 1'b0; req_wr = 1'b0; req_smi = 1'b0;
    endtask

    task automatic cfg_write(input logic [4:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset_state();
        expect_rsp("R9 outputs in reset", 1'b0, 32'h0, 5'b00000, 1'b0);
        rst_n = 1'b1;
        probe(32'h0000_1000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R9 limit zero sends low memory to PCI", 1'b1, 32'h0000_1000, 5'b00010, 1'b0);
        probe(32'h000A_0000, 1'b1, 1'b1, 1'b0);
        expect_rsp("R9 window starts closed", 1'b1, 32'h000A_0000, 5'b00000, 1'b0);
        probe(32'h000F_FFFF, 1'b0, 1'b1, 1'b0);
        expect_rsp("R9 last ROM byte closed", 1'b1, 32'h000F_FFFF, 5'b00000, 1'b0);
    endtask

    task automatic t_system_memory();
        cfg_write(5'd21, 32'h0400_0000);
        probe(32'h0009_FFFF, 1'b1, 1'b0, 1'b0);
        expect_rsp("R3 last byte below window", 1'b1, 32'h0009_FFFF, 5'b11100, 1'b1);
        probe(32'h0000_0000, 1'b0, 1'b1, 1'b0);
        expect_rsp("R3 address zero", 1'b1, 32'h0000_0000, 5'b11100, 1'b1);
        probe(32'h0010_0000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R4 first byte above 1MB", 1'b1, 32'h0010_0000, 5'b11100, 1'b1);
        probe(32'h03FF_FFFF, 1'b1, 1'b0, 1'b0);
        expect_rsp("R4 last byte below limit", 1'b1, 32'h03FF_FFFF, 5'b11100, 1'b1);
        probe(32'h0400_0000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R4 limit itself goes to PCI", 1'b1, 32'h0400_0000, 5'b00010, 1'b0);
        probe(32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0);
        expect_rsp("R4 top of space goes to PCI", 1'b1, 32'hFFFF_FFF0, 5'b00010, 1'b0);
    endtask

    task automatic t_display_regions();
        cfg_write(5'd0, 32'h1);
        cfg_write(5'd1, 32'h2);
        cfg_write(5'd2, 32'hC);
        probe(32'h000A_0000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R5 region0 first byte", 1'b1, 32'h000A_0000, 5'b10000, 1'b1);
        probe(32'h000A_FFFF, 1'b1, 1'b0, 1'b0);
        expect_rsp("R5 region0 last byte", 1'b1, 32'h000A_FFFF, 5'b10000, 1'b1);
        probe(32'h000B_0000, 1'b0, 1'b1, 1'b0);
        expect_rsp("R5 region1 first byte", 1'b1, 32'h000B_0000, 5'b01000, 1'b1);
        probe(32'h000B_7FFF, 1'b0, 1'b1, 1'b0);
        expect_rsp("R5 region1 last byte", 1'b1, 32'h000B_7FFF, 5'b01000, 1'b1);
        probe(32'h000B_8000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R5 region2 first byte", 1'b1, 32'h000B_8000, 5'b00110, 1'b0);
        probe(32'h000B_FFFF, 1'b1, 1'b0, 1'b0);
        expect_rsp("R5 region2 last byte", 1'b1, 32'h000B_FFFF, 5'b00110, 1'b0);
    endtask

    task automatic t_rom_segments();
        for (int k = 0; k < 16; k++) begin
            cfg_write(5'(3 + k), 32'(k));
        end
        for (int k = 0; k < 16; k++) begin
            logic [3:0]  n;
            logic [31:0] base;
            n = 4'(k);
            base = 32'h000C_0000 + 32'(k) * 32'h4000;
            probe(base, 1'b1, 1'b0, 1'b0);
            expect_rsp("R6 R7 segment first byte", 1'b1, base,
                       {n[0], n[1], n[2], n[3], 1'b0}, n[0]);
            probe(base + 32'h3FFF, 1'b0, 1'b1, 1'b0);
            expect_rsp("R6 R7 segment last byte", 1'b1, base + 32'h3FFF,
                       {n[0], n[1], n[2], n[3], 1'b0}, n[1]);
        end
    endtask

    task automatic t_redirect();
        cfg_write(5'd19, 32'h5);
        probe(32'h000B_8000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R8 redirect clears PCI, keeps cache", 1'b1, 32'h000B_8000, 5'b00101, 1'b0);
        probe(32'h000A_0000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R8 region0 redirect keeps read", 1'b1, 32'h000A_0000, 5'b10001, 1'b1);
        probe(32'h000B_0000, 1'b0, 1'b1, 1'b0);
        expect_rsp("R8 region1 bit clear", 1'b1, 32'h000B_0000, 5'b01000, 1'b1);
        probe(32'h000F_C000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R8 ROM segment never redirected", 1'b1, 32'h000F_C000, 5'b11110, 1'b1);
    endtask

    task automatic t_wrap_mask();
        probe(32'h001A_0000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R1 mask off leaves bit 20", 1'b1, 32'h001A_0000, 5'b11100, 1'b1);
        cfg_write(5'd20, 32'h1);
        probe(32'h001A_0000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R1 bit 20 cleared, lands in region0", 1'b1, 32'h000A_0000, 5'b10001, 1'b1);
        probe(32'h0010_0000, 1'b0, 1'b1, 1'b0);
        expect_rsp("R1 wraps to zero", 1'b1, 32'h0000_0000, 5'b11100, 1'b1);
        probe(32'h001A_0000, 1'b1, 1'b0, 1'b1);
        expect_rsp("R2 SMI access unmasked", 1'b1, 32'h001A_0000, 5'b11100, 1'b1);
    endtask

    task automatic t_permit();
        probe(32'h000A_0000, 1'b0, 1'b1, 1'b0);
        expect_rsp("R11 write into read-only region", 1'b1, 32'h000A_0000, 5'b10001, 1'b0);
        probe(32'h000A_0000, 1'b0, 1'b0, 1'b0);
        expect_rsp("R11 no strobe no permit", 1'b1, 32'h000A_0000, 5'b10001, 1'b0);
        probe(32'h000B_0000, 1'b1, 1'b1, 1'b0);
        expect_rsp("R11 either strobe suffices", 1'b1, 32'h000B_0000, 5'b01000, 1'b1);
    endtask

    task automatic t_timing_and_ignore();
        @(negedge clk);
        expect_rsp("R10 idle drops valid, holds fields", 1'b0, 32'h000B_0000, 5'b01000, 1'b1);
        cfg_write(5'd25, 32'hFFFF_FFFF);
        probe(32'h000A_0000, 1'b1, 1'b0, 1'b0);
        expect_rsp("R12 unused selector ignored", 1'b1, 32'h000A_0000, 5'b10001, 1'b1);
        cfg_we = 1'b1; cfg_sel = 5'd0; cfg_wdata = 32'hF;
        probe(32'h000A_0000, 1'b0, 1'b1, 1'b0);
        cfg_we = 1'b0;
        expect_rsp("R12 same-cycle request sees old", 1'b1, 32'h000A_0000, 5'b10001, 1'b0);
        probe(32'h000A_0000, 1'b0, 1'b1, 1'b0);
        expect_rsp("R12 next request sees new", 1'b1, 32'h000A_0000, 5'b11101, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_system_memory();
        t_display_regions();
        t_rom_segments();
        t_redirect();
        t_wrap_mask();
        t_permit();
        t_timing_and_ignore();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule